// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This unit turns a bank of polarity-adjusted input bits into grouped interrupt requests. Every pin has two paths to an interrupt. The level path is live: the input bit gated by a level-enable bit, with no storage. The edge path is latched: a 0-to-1 change on the input sets a sticky edge-cause bit, which is then gated by an edge-enable bit.

The two paths are ORed to give one cause bit per pin. The per-pin causes are ORed in runs of consecutive pins, one run per summary output, and the summary outputs are registered.

Software reaches the three stored registers (edge cause, edge enable, level enable) through a small word-wide write/read interface. Any input polarity or trigger direction is chosen upstream, before the bits arrive here.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset the edge-cause, edge-enable and level-enable registers all read 0 and every summary output is 0.
- R2: A write to byte address 0x18 replaces the edge-enable register and a write to 0x1C replaces the level-enable register. Reads at 0x14, 0x18 and 0x1C return edge cause, edge enable and level enable respectively. A read at any other address returns 0.
- R3: A pin whose level-enable bit is 1 drives its group's summary output from its input bit with no latching. The output falls once the input returns to 0.
- R4: A 0-to-1 change of an input bit, detected against that bit's value at the previous clock edge, sets its edge-cause bit at that edge. The bit stays set after the input falls.
- R5: A 1-to-0 change of an input bit leaves its edge-cause bit unchanged.
- R6: An edge-cause bit whose edge-enable bit is 0 remains readable at 0x14 but does not raise a summary output. Setting the enable bit later raises the output.
- R7: A write to 0x14 clears each edge-cause bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When a new rising edge and a clearing write reach the same edge-cause bit in the same cycle, the bit ends up set.
- R9: Summary output g is the OR of the per-pin causes of pins 8g to 8g+7.
- R10: Summary outputs are registered. They change on the clock edge after the per-pin cause changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 32 | Polarity-adjusted input bits |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_sum | output | 4 | Registered summary interrupts, one per group of eight pins |

## Verification
The bench first walks a single active pin across all 32 positions through the level path and then through the edge path. The level walk shows which group output each pin reaches and that the level path drops with its input. The edge walk shows that the cause latches on a rise and is not set by a fall. Mixed patterns set several cause bits at once, so that partial clear writes can be told apart from full clears. Separate cases cover a clear and a rise landing on the same bit in the same cycle, and an enable set after the cause was already latched. These show that a rise takes priority over a clear and that gating is applied after the cause is latched.

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int NPINS = 32,
  parameter int GROUP = 8,
  parameter int AW    = 8,
  parameter logic [AW-1:0] A_CAUSE = 8'h14,
  parameter logic [AW-1:0] A_EMASK = 8'h18,
  parameter logic [AW-1:0] A_LMASK = 8'h1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS/GROUP-1:0] irq_sum
);
  localparam int NGRP = NPINS / GROUP;

  logic [NPINS-1:0] din_q, edge_cause, edge_en, lvl_en, rise, pin_cause;
  logic [NGRP-1:0]  grp_any;

  assign rise      = din & ~din_q;
  assign pin_cause = (din & lvl_en) | (edge_cause & edge_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q      <= '0;
      edge_cause <= '0;
      edge_en    <= '0;
      lvl_en     <= '0;
    end else begin
      din_q <= din;
      if (bus_wr && bus_addr == A_CAUSE) edge_cause <= (edge_cause & bus_wdata) | rise;
      else                               edge_cause <= edge_cause | rise;
      if (bus_wr && bus_addr == A_EMASK) edge_en <= bus_wdata;
      if (bus_wr && bus_addr == A_LMASK) lvl_en  <= bus_wdata;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |pin_cause[g*GROUP +: GROUP];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_sum <= '0;
    else        irq_sum <= grp_any;

  always_comb begin
    unique case (bus_addr)
      A_CAUSE: bus_rdata = edge_cause;
      A_EMASK: bus_rdata = edge_en;
      A_LMASK: bus_rdata = lvl_en;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio_irq_cause_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 8,
  parameter logic [AW-1:0] A_CAUSE = 8'h14,
  parameter logic [AW-1:0] A_EMASK = 8'h18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] din,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] cause,
  input logic [NPINS-1:0] emask
);
  logic [NPINS-1:0] prev_c;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_c <= '0;
    else        prev_c <= din;

  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((din & ~prev_c) != '0) |=> ((cause & $past(din & ~prev_c)) == $past(din & ~prev_c)));

  p_no_set_without_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(din & ~prev_c)) == '0));

  p_clear_keeps_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CAUSE && (din & ~prev_c) == '0) |=> cause == $past(cause & bus_wdata));

  p_rise_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CAUSE) |=> ((cause & $past(din & ~prev_c)) == $past(din & ~prev_c)));

  p_emask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EMASK) |=> emask == $past(bus_wdata));
endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(.NPINS(NPINS), .AW(AW), .A_CAUSE(A_CAUSE), .A_EMASK(A_EMASK))
  u_chk (.clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr), .bus_wr(bus_wr),
         .bus_wdata(bus_wdata), .cause(edge_cause), .emask(edge_en));

// File: tb/gpio_irq_cause_test.sv
module gpio_irq_cause_test;
  logic        clk = 0, rst_n = 0;
  logic [31:0] din = 0, bus_wdata = 0, bus_rdata;
  logic [7:0]  bus_addr = 8'h14;
  logic        bus_wr = 0;
  logic [3:0]  irq_sum;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [31:0] m_cause = 0, m_em = 0, m_lm = 0, m_prev = 0;
  logic [3:0]  m_irq = 0;
  string cur = "R1";

  gpio_irq_cause uut (.clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sum(irq_sum));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] grp(logic [31:0] v);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |v[g*8 +: 8];
    return r;
  endfunction

  task automatic tick();
    logic [31:0] rise;
    @(posedge clk);
    cycles++;
    rise   = din & ~m_prev;
    m_irq  = grp((din & m_lm) | (m_cause & m_em));
    if (bus_wr && bus_addr == 8'h14) m_cause = (m_cause & bus_wdata) | rise;
    else                             m_cause = m_cause | rise;
    if (bus_wr && bus_addr == 8'h18) m_em = bus_wdata;
    if (bus_wr && bus_addr == 8'h1C) m_lm = bus_wdata;
    m_prev = din;
    #1;
    bus_wr = 0; bus_addr = 8'h14;
    #1;
    chk({cur, " irq"}, {28'b0, irq_sum}, {28'b0, m_irq});
    chk({cur, " cause"}, bus_rdata, m_cause);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
    bus_addr = 8'h14; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", {28'b0, irq_sum}, 32'h0);
    rd("R1 cause", 8'h14, 0); rd("R1 emask", 8'h18, 0); rd("R1 lmask", 8'h1C, 0);
    rst_n = 1;
    tick();
    // R2 register access
    cur = "R2";
    wr(8'h18, 32'hA5A5_0F0F); wr(8'h1C, 32'h1234_5678);
    rd("R2 emask", 8'h18, 32'hA5A5_0F0F); rd("R2 lmask", 8'h1C, 32'h1234_5678);
    rd("R2 unmapped", 8'h10, 0); rd("R2 unmapped", 8'h20, 0);
    wr(8'h18, 0); wr(8'h1C, 0);

    // R3, R9, R10 level walk
    cur = "R3";
    for (int p = 0; p < 32; p++) begin
      wr(8'h1C, 32'h1 << p);
      din = 32'h1 << p; #1;
      chk("R10 before edge", {28'b0, irq_sum}, 0);
      tick();
      chk("R9 group", {28'b0, irq_sum}, 32'h1 << (p / 8));
      din = 0; tick();
      chk("R3 unlatched", {28'b0, irq_sum}, 0);
      wr(8'h14, 0);
    end
    wr(8'h1C, 0);

    // R4, R5, R7 edge walk
    cur = "R4";
    wr(8'h18, 32'hFFFF_FFFF);
    for (int p = 0; p < 32; p++) begin
      din = 32'h1 << p; tick();
      chk("R10 latency", {28'b0, irq_sum}, 0);
      tick();
      chk("R4 edge irq", {28'b0, irq_sum}, 32'h1 << (p / 8));
      din = 0; tick(); tick();
      chk("R5 fall keeps", bus_rdata, 32'h1 << p);
      chk("R4 latched", {28'b0, irq_sum}, 32'h1 << (p / 8));
      wr(8'h14, ~(32'h1 << p));
      chk("R7 cleared", bus_rdata, 0);
      tick();
    end

    // R5 fall only
    cur = "R5";
    din = 32'hFFFF_FFFF; tick(); wr(8'h14, 0);
    din = 0; tick(); tick();
    chk("R5 no fall capture", bus_rdata, 0);

    // R7 partial clear
    cur = "R7";
    din = 32'h8181_4242; tick(); din = 0; tick();
    wr(8'h14, 32'h8000_4002);
    chk("R7 partial", bus_rdata, 32'h8000_4002);
    wr(8'h14, 0);

    // R8 rise against clear
    cur = "R8";
    din = 32'h10; tick(); din = 0; tick();
    din = 32'h8; bus_addr = 8'h14; bus_wdata = 0; bus_wr = 1; tick();
    chk("R8 rise wins", bus_rdata, 32'h8);
    din = 0; wr(8'h14, 0);

    // R6 gating
    cur = "R6";
    wr(8'h18, 0);
    din = 32'h0100_0020; tick(); din = 0; tick(); tick();
    chk("R6 masked irq", {28'b0, irq_sum}, 0);
    chk("R6 cause visible", bus_rdata, 32'h0100_0020);
    wr(8'h18, 32'h0000_0020); tick();
    chk("R6 unmask", {28'b0, irq_sum}, 4'b0001);
    wr(8'h18, 32'hFFFF_FFFF); tick();
    chk("R9 two groups", {28'b0, irq_sum}, 4'b1001);
    wr(8'h14, 0); tick();
    chk("R7 all clear", {28'b0, irq_sum}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule